// File: doc/BRIEF.md
# Paged Pointer Effective Address Unit

This block forms memory addresses for a small 8-bit accumulator machine that has a 16-bit program counter and three 16-bit pointer registers. Each cycle it accepts one command. The command can advance the program counter past a fetched instruction byte, form an operand address from a 3-bit mode/pointer field and a displacement byte, load the target of a relative jump into the program counter, or overwrite one register with a value computed elsewhere. An example of the last case is an accumulator/pointer exchange.

All address arithmetic stays inside a 4 KB page. A signed 8-bit offset is added to the low twelve bits, and the carry out of bit 11 is discarded, so the top four bits never change. A displacement of 0x80 means "use the extension register value as the signed offset". In the auto-indexed modes the selected pointer is moved before the access when the offset is negative, and after the access otherwise. The new pointer value is shown on a one-cycle write-back strobe. Instruction decode, memory access and the ALU sit outside this block.

Top module: `ea_unit`

## Requirements
- R1: After a synchronous active-low reset, `pc` is 0x0000 and all three pointers are 0x0000. `ea_valid`, `ea_imm` and `wb_stb` are low.
- R2: Command FETCH (cmd=1) advances `pc` by one in the next cycle, with the 12-bit page wrap. For example, 0x1FFF advances to 0x1000.
- R3: Bits 1..0 of `field` select the base register: 0 selects PC, 1 selects pointer 1, 2 selects pointer 2 and 3 selects pointer 3. When PC is the base, its current value is used, which is the value after the displacement byte has been fetched.
- R4: For command ADDR, a `disp` of 0x80 is replaced by `ext`, taken as a signed offset. Any other `disp` is sign-extended.
- R5: For command ADDR (cmd=2) with `field[2]`=0 (indexed), the cycle after the command shows `ea_valid`=1 and `ea_addr` = base + offset, with the page wrap. No register changes and `wb_stb` stays low.
- R6: For command ADDR with `field[2]`=1, a nonzero pointer select and a negative offset, `ea_addr` and the pointer both become base + offset. `wb_stb` pulses with `wb_idx` set to the pointer number and `wb_val` set to the new value.
- R7: For the same auto-indexed mode with an offset of zero or more, `ea_addr` is the old base value. The pointer becomes base + offset, and this is reported on `wb_stb`/`wb_idx`/`wb_val`.
- R8: For command ADDR with `field`=4 (immediate), the next cycle shows `ea_imm`=1, `ea_valid`=0, `ea_addr`=0 and `imm_data`=`disp`. No register changes and `wb_stb` stays low.
- R9: Command JUMP (cmd=3) loads `pc` with the selected base plus the sign-extended `disp`, with the page wrap. Here 0x80 counts as -128 and `ext` is not used.
- R10: Command LOAD (cmd=4) writes `load_val` into the register selected by `field[1:0]`.
- R11: The outputs are registered and appear one cycle after the command. When not in use, `ea_addr`, `imm_data`, `wb_idx` and `wb_val` are zero. IDLE (cmd=0) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd | input | 3 | Command: 0 idle, 1 fetch, 2 address, 3 jump, 4 load |
| field | input | 3 | Mode bit (2) and base/pointer select (1..0) |
| disp | input | 8 | Displacement byte |
| ext | input | 8 | Extension register value |
| load_val | input | 16 | Value written by LOAD |
| pc | output | 16 | Current program counter |
| ea_valid | output | 1 | A memory address is presented |
| ea_imm | output | 1 | Immediate operand presented instead of an address |
| ea_addr | output | 16 | Effective address |
| imm_data | output | 8 | Immediate operand byte |
| wb_stb | output | 1 | Pointer write-back strobe |
| wb_idx | output | 2 | Pointer number written back |
| wb_val | output | 16 | Value written back |

## Verification
The address path is driven with each base register and with offsets that are small positive, negative (0xFF), the 0x80 escape with both positive and negative extension values, and zero. Carries across bit 11 in both directions show whether the page bits are kept. Auto-indexed runs on the same pointer, one after another, separate pre-decrement from post-increment, because every later address depends on the value that was written back. Jumps with 0x80 and indexed reads after writes show that the escape only applies to data addresses and that indexed mode leaves pointers unchanged.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_FETCH = 3'd1,
        CMD_ADDR  = 3'd2,
        CMD_JUMP  = 3'd3,
        CMD_LOAD  = 3'd4
    } ea_cmd_e;

    localparam int MODE_BIT = 2;

endpackage

// File: rtl/ea_page_add.sv
module ea_page_add #(
    parameter int AW = 16,
    parameter int PB = 12,
    parameter int OW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] off,
    output logic [AW-1:0] sum
);
    localparam int XW = PB - OW;

    logic [PB-1:0] off_x;
    logic [PB-1:0] low;

    assign off_x = {{XW{off[OW-1]}}, off};
    assign low   = base[PB-1:0] + off_x;
    assign sum   = {base[AW-1:PB], low};

endmodule

// File: rtl/ea_off_sel.sv
module ea_off_sel #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] disp,
    input  logic [DW-1:0] ext,
    output logic [DW-1:0] off
);
    localparam logic [DW-1:0] ESCAPE = {1'b1, {(DW-1){1'b0}}};

    assign off = (disp == ESCAPE) ? ext : disp;

endmodule

// File: rtl/ea_regfile.sv
module ea_regfile #(
    parameter int AW   = 16,
    parameter int NREG = 4,
    localparam int IW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IW-1:0]            widx,
    input  logic [AW-1:0]            wdata,
    output logic [NREG-1:0][AW-1:0]  regs
);
    logic [NREG-1:0][AW-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[widx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs_q[$past(widx)] == $past(wdata));

endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
    parameter int AW = 16,
    parameter int PB = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cmd,
    input  logic [2:0]    field,
    input  logic [DW-1:0] disp,
    input  logic [DW-1:0] ext,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] pc,
    output logic          ea_valid,
    output logic          ea_imm,
    output logic [AW-1:0] ea_addr,
    output logic [DW-1:0] imm_data,
    output logic          wb_stb,
    output logic [1:0]    wb_idx,
    output logic [AW-1:0] wb_val
);
    import ea_pkg::*;

    localparam int NREG = 4;
    localparam int IW   = $clog2(NREG);
    localparam logic [IW-1:0] PC_IDX = '0;
    localparam logic [DW-1:0] ONE    = DW'(1);

    typedef struct packed {
        logic          ea_valid;
        logic          ea_imm;
        logic [AW-1:0] ea_addr;
        logic [DW-1:0] imm_data;
        logic          wb_stb;
        logic [IW-1:0] wb_idx;
        logic [AW-1:0] wb_val;
    } out_t;

    out_t out_d, out_q;

    logic                    rf_we;
    logic [IW-1:0]           rf_widx;
    logic [AW-1:0]           rf_wdata;
    logic [NREG-1:0][AW-1:0] regs;

    logic [IW-1:0] sel;
    logic [AW-1:0] base, pc_cur, pc_inc, ea_sum, jmp_sum;
    logic [DW-1:0] off;
    ea_cmd_e       cmd_e;

    assign cmd_e  = ea_cmd_e'(cmd);
    assign sel    = field[IW-1:0];
    assign base   = regs[sel];
    assign pc_cur = regs[PC_IDX];

    ea_regfile #(.AW(AW), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .widx(rf_widx),
        .wdata(rf_wdata), .regs(regs)
    );

    ea_off_sel #(.DW(DW)) u_off (.disp(disp), .ext(ext), .off(off));

    ea_page_add #(.AW(AW), .PB(PB), .OW(DW)) u_inc (
        .base(pc_cur), .off(ONE), .sum(pc_inc));
    ea_page_add #(.AW(AW), .PB(PB), .OW(DW)) u_ea (
        .base(base), .off(off), .sum(ea_sum));
    ea_page_add #(.AW(AW), .PB(PB), .OW(DW)) u_jmp (
        .base(base), .off(disp), .sum(jmp_sum));

    always_comb begin
        out_d    = '0;
        rf_we    = 1'b0;
        rf_widx  = PC_IDX;
        rf_wdata = '0;
        unique case (cmd_e)
            CMD_FETCH: begin
                rf_we    = 1'b1;
                rf_wdata = pc_inc;
            end
            CMD_ADDR: begin
                if (!field[MODE_BIT]) begin
                    out_d.ea_valid = 1'b1;
                    out_d.ea_addr  = ea_sum;
                end else if (sel == PC_IDX) begin
                    out_d.ea_imm   = 1'b1;
                    out_d.imm_data = disp;
                end else begin
                    out_d.ea_valid = 1'b1;
                    out_d.ea_addr  = off[DW-1] ? ea_sum : base;
                    out_d.wb_stb   = 1'b1;
                    out_d.wb_idx   = sel;
                    out_d.wb_val   = ea_sum;
                    rf_we          = 1'b1;
                    rf_widx        = sel;
                    rf_wdata       = ea_sum;
                end
            end
            CMD_JUMP: begin
                rf_we    = 1'b1;
                rf_wdata = jmp_sum;
            end
            CMD_LOAD: begin
                rf_we    = 1'b1;
                rf_widx  = sel;
                rf_wdata = load_val;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pc       = pc_cur;
    assign ea_valid = out_q.ea_valid;
    assign ea_imm   = out_q.ea_imm;
    assign ea_addr  = out_q.ea_addr;
    assign imm_data = out_q.imm_data;
    assign wb_stb   = out_q.wb_stb;
    assign wb_idx   = out_q.wb_idx;
    assign wb_val   = out_q.wb_val;

    a_r2_fetch_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd) == 3'd1 |-> pc[AW-1:PB] == $past(pc[AW-1:PB]));
    a_r5_indexed_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd) == 3'd2 && !$past(field[2])) |-> (!wb_stb && ea_valid));
    a_r5_addr_keeps_pc: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd) == 3'd2 |-> $stable(pc));
    a_r8_imm_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        ea_imm |-> (!wb_stb && !ea_valid));
    a_r6_wb_has_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb |-> (ea_valid && wb_idx != 2'd0));
    a_r9_jump_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd) == 3'd3 && $past(field[1:0]) == 2'd0)
            |-> pc[AW-1:PB] == $past(pc[AW-1:PB]));
    a_r11_idle_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd) == 3'd0 |-> ($stable(pc) && !wb_stb && !ea_valid));

endmodule

// File: tb/ea_unit_test.sv
module ea_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = '0, field = '0;
    logic [7:0]  disp = '0, ext = '0;
    logic [15:0] load_val = '0;
    logic [15:0] pc, ea_addr, wb_val;
    logic        ea_valid, ea_imm, wb_stb;
    logic [7:0]  imm_data;
    logic [1:0]  wb_idx;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ea_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .field(field), .disp(disp),
        .ext(ext), .load_val(load_val), .pc(pc), .ea_valid(ea_valid),
        .ea_imm(ea_imm), .ea_addr(ea_addr), .imm_data(imm_data),
        .wb_stb(wb_stb), .wb_idx(wb_idx), .wb_val(wb_val)
    );

    typedef struct {
        logic [15:0] pc;
        logic        v;
        logic        imm;
        logic [15:0] addr;
        logic [7:0]  idat;
        logic        stb;
        logic [1:0]  idx;
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] m[4];

    function automatic logic [15:0] wrap(input logic [15:0] b, input logic [7:0] o);
        logic [11:0] lo;
        lo = b[11:0] + {{4{o[7]}}, o};
        return {b[15:12], lo};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic [2:0] f, input logic [7:0] d,
                         input logic [7:0] x, input logic [15:0] lv, input string tag);
        exp_t        e;
        logic [7:0]  off;
        logic [15:0] b, s;
        @(negedge clk);
        cmd = c; field = f; disp = d; ext = x; load_val = lv;
        e = '{pc: 16'h0, v: 1'b0, imm: 1'b0, addr: 16'h0, idat: 8'h0,
              stb: 1'b0, idx: 2'd0, val: 16'h0, tag: tag};
        b   = m[f[1:0]];
        off = (d == 8'h80) ? x : d;
        s   = wrap(b, off);
        case (c)
            3'd1: m[0] = wrap(m[0], 8'h01);
            3'd2: begin
                if (!f[2]) begin
                    e.v = 1'b1; e.addr = s;
                end else if (f[1:0] == 2'd0) begin
                    e.imm = 1'b1; e.idat = d;
                end else begin
                    e.v = 1'b1; e.addr = off[7] ? s : b;
                    e.stb = 1'b1; e.idx = f[1:0]; e.val = s;
                    m[f[1:0]] = s;
                end
            end
            3'd3: m[0] = wrap(b, d);
            3'd4: m[f[1:0]] = lv;
            default: ;
        endcase
        e.pc = m[0];
        q.push_back(e);
    endtask

    always begin
        @(posedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(pc == e.pc, e.tag, "pc", pc, e.pc);
            chk(ea_valid == e.v, e.tag, "ea_valid", 16'(ea_valid), 16'(e.v));
            chk(ea_imm == e.imm, e.tag, "ea_imm", 16'(ea_imm), 16'(e.imm));
            chk(ea_addr == e.addr, e.tag, "ea_addr", ea_addr, e.addr);
            chk(imm_data == e.idat, e.tag, "imm_data", 16'(imm_data), 16'(e.idat));
            chk(wb_stb == e.stb, e.tag, "wb_stb", 16'(wb_stb), 16'(e.stb));
            chk(wb_idx == e.idx, e.tag, "wb_idx", 16'(wb_idx), 16'(e.idx));
            chk(wb_val == e.val, e.tag, "wb_val", wb_val, e.val);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m[i] = 16'h0;
        cmd = 3'd1; field = 3'd5; disp = 8'h44;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(pc == 16'h0, "R1", "pc", pc, 16'h0);
        chk(!ea_valid && !ea_imm && !wb_stb, "R1", "flags",
            {13'h0, ea_valid, ea_imm, wb_stb}, 16'h0);
        cmd = 3'd0;
        rst_n = 1'b1;
        // R1 pointers zero, observed through indexed addressing
        issue(3'd2, 3'd1, 8'h00, 8'h00, 16'h0, "R1");
        issue(3'd2, 3'd2, 8'h00, 8'h00, 16'h0, "R1");
        issue(3'd2, 3'd3, 8'h00, 8'h00, 16'h0, "R1");
        // R2 fetch
        issue(3'd1, 3'd0, 8'h00, 8'h00, 16'h0, "R2");
        issue(3'd1, 3'd0, 8'h00, 8'h00, 16'h0, "R2");
        issue(3'd0, 3'd0, 8'h00, 8'h00, 16'h0, "R11");
        // R10 loads, then R2 page wrap
        issue(3'd4, 3'd0, 8'h00, 8'h00, 16'h1FFE, "R10");
        issue(3'd1, 3'd0, 8'h00, 8'h00, 16'h0, "R2");
        issue(3'd1, 3'd0, 8'h00, 8'h00, 16'h0, "R2");
        issue(3'd4, 3'd1, 8'h00, 8'h00, 16'h2345, "R10");
        issue(3'd4, 3'd2, 8'h00, 8'h00, 16'h3FF0, "R10");
        issue(3'd4, 3'd3, 8'h00, 8'h00, 16'h8000, "R10");
        // R3 / R5 indexed on each base
        issue(3'd2, 3'd1, 8'h10, 8'h00, 16'h0, "R3");
        issue(3'd2, 3'd2, 8'h20, 8'h00, 16'h0, "R5");
        issue(3'd2, 3'd3, 8'hFF, 8'h00, 16'h0, "R5");
        issue(3'd2, 3'd0, 8'h05, 8'h00, 16'h0, "R3");
        issue(3'd2, 3'd2, 8'h00, 8'h00, 16'h0, "R5");
        // R4 escape value
        issue(3'd2, 3'd1, 8'h80, 8'h05, 16'h0, "R4");
        issue(3'd2, 3'd1, 8'h80, 8'hFE, 16'h0, "R4");
        issue(3'd2, 3'd1, 8'h7F, 8'hFE, 16'h0, "R4");
        // R7 / R6 auto-indexing
        issue(3'd2, 3'd5, 8'h02, 8'h00, 16'h0, "R7");
        issue(3'd2, 3'd5, 8'hFF, 8'h00, 16'h0, "R6");
        issue(3'd2, 3'd5, 8'h80, 8'hF0, 16'h0, "R6");
        issue(3'd2, 3'd5, 8'h00, 8'h00, 16'h0, "R7");
        issue(3'd2, 3'd6, 8'h10, 8'h00, 16'h0, "R7");
        issue(3'd2, 3'd7, 8'hFF, 8'h00, 16'h0, "R6");
        issue(3'd2, 3'd1, 8'h00, 8'h00, 16'h0, "R6");
        // R8 immediate
        issue(3'd2, 3'd4, 8'h3C, 8'h11, 16'h0, "R8");
        issue(3'd2, 3'd4, 8'h80, 8'h11, 16'h0, "R8");
        // R9 jumps
        issue(3'd3, 3'd0, 8'h10, 8'h00, 16'h0, "R9");
        issue(3'd3, 3'd2, 8'h80, 8'h05, 16'h0, "R9");
        issue(3'd3, 3'd3, 8'hFF, 8'h00, 16'h0, "R9");
        issue(3'd1, 3'd0, 8'h00, 8'h00, 16'h0, "R2");
        issue(3'd0, 3'd3, 8'h80, 8'h00, 16'h0, "R11");
        @(negedge clk);
        cmd = 3'd0;
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule